// File: doc/BRIEF.md
# Program-Mode Address Pointer and Access Guard

This block holds the 14-bit address pointer that a serial program/verify engine uses, and it decides whether the memory location under the pointer may be read back and programmed. The pointer reacts to three single-cycle pulses: a mode clear, a jump into configuration space, and a step forward. The lower half of the logical space (0x0000 to 0x1FFF) is user memory. The upper half (0x2000 to 0x3FFF) is configuration memory.

Stepping wraps inside whichever half the pointer is in. Once the pointer has jumped into configuration space, only a mode clear can bring it back to user memory. The physical array address is the pointer folded onto the implemented array size.

The access guard decodes a code-protection field, which the stored configuration word holds in four copies. From that field it drives two outputs: a flag that forces returned data to zero, and a write enable. It also reports when the copies disagree and when the pointer sits on a reserved configuration address. The serial shifting, the array, the voltages and the pulse timing belong to neighbouring logic.

Top module: `pgm_addr_guard`

## Requirements
- R1: After reset the pointer `log_addr` is 0x0000 and the pointer is in user space.
- R2: In user space a step pulse adds one to the pointer, and a step from 0x1FFF gives 0x0000.
- R3: A config-jump pulse sets the pointer to 0x2000. From then on, bit 13 of the pointer stays 1 across steps, and a step from 0x3FFF gives 0x2000.
- R4: A mode-clear pulse sets the pointer to 0x0000 and leaves config space in the same cycle. When pulses coincide, mode clear wins over config jump, and config jump wins over step. All pointer changes appear on the clock edge that samples the pulse.
- R5: `phys_addr` equals the low ARRAY_AW bits of the pointer: 0x7FF mask for 2K words (ARRAY_AW=11), 0x3FF mask for 1K words (ARRAY_AW=10).
- R6: The protection code cp (2 bits) selects a protected range of physical user addresses:
  - 2'b11: nothing is protected.
  - 2'b10: 0x400 and up are protected.
  - 2'b01: 0x200 and up are protected.
  - 2'b00: every address is protected.
- R7: At a protected user location `rd_zero`=1 and `wr_en`=0. At an unprotected user location `rd_zero`=0 and `wr_en`=1.
- R8: The last implemented physical location (all ones) is never protected.
- R9: cp is held in four copies, at configuration word bits [13:12], [11:10], [9:8] and [5:4]. If any copy differs from the others, `cp_mismatch`=1 and the array is treated as unprotected.
- R10: In config space, addresses 0x2000 to 0x2003 and 0x2007 give `rd_zero`=0, `wr_en`=1 and `reserved_hit`=0. Every other config address gives `reserved_hit`=1, `wr_en`=0 and `rd_zero`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_clr | input | 1 | Pulse: leave program mode state, pointer to 0x0000 |
| cfg_jump | input | 1 | Pulse: pointer to 0x2000, enter config space |
| step | input | 1 | Pulse: advance pointer by one within current half |
| cfg_word | input | 14 | Stored configuration word holding the protection copies |
| log_addr | output | 14 | Logical pointer |
| phys_addr | output | ARRAY_AW | Pointer folded onto the implemented array |
| rd_zero | output | 1 | Returned data must be forced to zero |
| wr_en | output | 1 | Programming of the current location allowed |
| cp_mismatch | output | 1 | Protection copies disagree |
| reserved_hit | output | 1 | Pointer is on a reserved config address |

## Verification
The pointer is stepped through long runs that cross both wrap points. These runs tell apart a wrap that stays in its own half from one that falls into the other half. Coincident pulses are applied to separate the priority order.

The protection decode is tried with each of the four codes, at addresses just below and just above each range boundary. Addresses above the array size are also tried, so that folding errors and off-by-one range limits show up. The calibration word is checked under full protection.

Configuration words whose copies disagree in a single copy show whether every copy takes part in the comparison. A walk over config space separates the ID words and the configuration word from the reserved addresses.

// File: rtl/pgm_guard_pkg.sv
package pgm_guard_pkg;
  localparam int PTR_W  = 14;
  localparam int HALF_W = PTR_W - 1;
  localparam int CFGW_W = 14;

  typedef logic [PTR_W-1:0] ptr_t;

  // Advance within the half selected by the top bit.
  function automatic ptr_t step_in_half(ptr_t p);
    logic [HALF_W-1:0] low;
    low = p[HALF_W-1:0] + 1'b1;
    return {p[PTR_W-1], low};
  endfunction

  // Protected-range test on a physical index widened to 12 bits.
  function automatic logic in_prot_range(logic [1:0] cp, logic [11:0] idx);
    logic r;
    case (cp)
      2'b00:   r = 1'b1;
      2'b01:   r = (idx >= 12'h200);
      2'b10:   r = (idx >= 12'h400);
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pgm_ptr_core.sv
module pgm_ptr_core
  import pgm_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_clr,
  input  logic cfg_jump,
  input  logic step,
  output ptr_t ptr,
  output logic in_cfg
);
  localparam ptr_t CFG_BASE = ptr_t'(1) << HALF_W;

  ptr_t ptr_nxt;
  logic in_cfg_nxt;

  always_comb begin
    ptr_nxt    = ptr;
    in_cfg_nxt = in_cfg;
    if (mode_clr) begin
      ptr_nxt    = '0;
      in_cfg_nxt = 1'b0;
    end else if (cfg_jump) begin
      ptr_nxt    = CFG_BASE;
      in_cfg_nxt = 1'b1;
    end else if (step) begin
      ptr_nxt = step_in_half(ptr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      in_cfg <= 1'b0;
    end else begin
      ptr    <= ptr_nxt;
      in_cfg <= in_cfg_nxt;
    end
  end

  // R2: user-half wrap
  assert_user_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !mode_clr && !cfg_jump && ptr == 14'h1FFF) |=> (ptr == 14'h0000));
  // R3: config-half wrap
  assert_cfg_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !mode_clr && !cfg_jump && ptr == 14'h3FFF) |=> (ptr == 14'h2000));
  // R3: top bit held in config space
  assert_cfg_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cfg && !mode_clr) |=> (in_cfg && ptr[PTR_W-1]));
  // R4: clear wins
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clr |=> (ptr == '0 && !in_cfg));
  // R3: jump lands on config base
  assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_jump && !mode_clr) |=> (ptr == CFG_BASE));
endmodule

// File: rtl/pgm_cp_decode.sv
module pgm_cp_decode
  import pgm_guard_pkg::*;
#(
  parameter int N_COPIES = 4
) (
  input  logic [CFGW_W-1:0] cfg_word,
  output logic [1:0]        cp_eff,
  output logic              cp_mismatch
);
  // Bit positions of each protection copy (low bit of the pair).
  localparam int COPY_LSB [4] = '{12, 10, 8, 4};

  logic [1:0] copy_v [N_COPIES];
  logic [N_COPIES-1:0] copy_eq;

  for (genvar g = 0; g < N_COPIES; g++) begin : g_copy
    assign copy_v[g]  = cfg_word[COPY_LSB[g] +: 2];
    assign copy_eq[g] = (copy_v[g] == copy_v[0]);
  end

  logic cfg_unused;
  assign cfg_unused = ^{cfg_word[7:6], cfg_word[3:0]};

  assign cp_mismatch = ~&copy_eq;
  assign cp_eff      = cp_mismatch ? 2'b11 : copy_v[0];

  // R9: a mismatch always disables protection
  always_comb begin
    assert_mismatch_open_R9: assert (!cp_mismatch || cp_eff == 2'b11);
  end
endmodule

// File: rtl/pgm_access_guard.sv
module pgm_access_guard
  import pgm_guard_pkg::*;
#(
  parameter int ARRAY_AW = 11,
  parameter int N_ID     = 4,
  parameter int CFGW_OFS = 7
) (
  input  ptr_t                ptr,
  input  logic                in_cfg,
  input  logic [1:0]          cp_eff,
  output logic [ARRAY_AW-1:0] phys_addr,
  output logic                rd_zero,
  output logic                wr_en,
  output logic                reserved_hit
);
  localparam logic [ARRAY_AW-1:0] CAL_LOC = '1;

  logic [11:0] phys_wide;
  logic        is_cal, prot_hit, cfg_ok;
  logic [HALF_W-1:0] cfg_ofs;

  assign phys_addr = ptr[ARRAY_AW-1:0];
  assign phys_wide = 12'(phys_addr);
  assign is_cal    = (phys_addr == CAL_LOC);
  assign prot_hit  = in_prot_range(cp_eff, phys_wide) && !is_cal;
  assign cfg_ofs   = ptr[HALF_W-1:0];
  assign cfg_ok    = (cfg_ofs < HALF_W'(N_ID)) || (cfg_ofs == HALF_W'(CFGW_OFS));

  logic top_unused;
  assign top_unused = ptr[PTR_W-1];

  always_comb begin
    if (in_cfg) begin
      rd_zero      = 1'b0;
      wr_en        = cfg_ok;
      reserved_hit = !cfg_ok;
    end else begin
      rd_zero      = prot_hit;
      wr_en        = !prot_hit;
      reserved_hit = 1'b0;
    end
  end

  always_comb begin
    // R7: masked read never pairs with a write
    assert_mask_blocks_wr_R7: assert (!(rd_zero && wr_en));
    // R8: calibration word stays open in user space
    assert_cal_open_R8: assert (in_cfg || !is_cal || wr_en);
    // R10: reserved config words are not writable
    assert_reserved_nowr_R10: assert (!reserved_hit || !wr_en);
  end
endmodule

// File: rtl/pgm_addr_guard.sv
module pgm_addr_guard
  import pgm_guard_pkg::*;
#(
  parameter int ARRAY_AW = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_clr,
  input  logic                cfg_jump,
  input  logic                step,
  input  logic [13:0]         cfg_word,
  output logic [13:0]         log_addr,
  output logic [ARRAY_AW-1:0] phys_addr,
  output logic                rd_zero,
  output logic                wr_en,
  output logic                cp_mismatch,
  output logic                reserved_hit
);
  ptr_t       ptr;
  logic       in_cfg;
  logic [1:0] cp_eff;

  pgm_ptr_core u_ptr (
    .clk(clk), .rst_n(rst_n), .mode_clr(mode_clr), .cfg_jump(cfg_jump),
    .step(step), .ptr(ptr), .in_cfg(in_cfg)
  );

  pgm_cp_decode #(.N_COPIES(4)) u_cp (
    .cfg_word(cfg_word), .cp_eff(cp_eff), .cp_mismatch(cp_mismatch)
  );

  pgm_access_guard #(.ARRAY_AW(ARRAY_AW)) u_guard (
    .ptr(ptr), .in_cfg(in_cfg), .cp_eff(cp_eff), .phys_addr(phys_addr),
    .rd_zero(rd_zero), .wr_en(wr_en), .reserved_hit(reserved_hit)
  );

  assign log_addr = ptr;

  // R5: physical address is the folded pointer
  assert_fold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr == log_addr[ARRAY_AW-1:0]);
  // R1: config space only after a jump
  assert_cfg_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(log_addr[13]) |-> $past(cfg_jump));
endmodule

// File: tb/pgm_addr_guard_test.sv
module pgm_addr_guard_test;
  logic clk = 0, rst_n = 0, mode_clr = 0, cfg_jump = 0, step = 0;
  logic [13:0] cfg_word = 14'h3FFF;
  logic [13:0] log_addr;
  logic [10:0] phys_addr;
  logic rd_zero, wr_en, cp_mismatch, reserved_hit;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pgm_addr_guard uut (
    .clk(clk), .rst_n(rst_n), .mode_clr(mode_clr), .cfg_jump(cfg_jump),
    .step(step), .cfg_word(cfg_word), .log_addr(log_addr),
    .phys_addr(phys_addr), .rd_zero(rd_zero), .wr_en(wr_en),
    .cp_mismatch(cp_mismatch), .reserved_hit(reserved_hit)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mk_cfg(logic [1:0] cp);
    return {cp, cp, cp, 2'b10, cp, 4'b0110};
  endfunction

  task automatic pulse_clr();
    @(negedge clk) mode_clr = 1; @(negedge clk) mode_clr = 0;
  endtask
  task automatic pulse_jump();
    @(negedge clk) cfg_jump = 1; @(negedge clk) cfg_jump = 0;
  endtask
  task automatic steps(int n);
    if (n > 0) begin
      @(negedge clk) step = 1;
      repeat (n) @(negedge clk);
      step = 0;
    end
  endtask
  task automatic go_user(int a);
    pulse_clr(); steps(a);
  endtask

  // Bench view of the protection rule, written as a threshold.
  function automatic int exp_masked(logic [1:0] cp, int a);
    int p = a % 2048;
    int lo = (cp == 2'b00) ? 0 : (cp == 2'b01) ? 'h200 : (cp == 2'b10) ? 'h400 : 99999;
    if (p == 2047) return 0;
    return (p >= lo) ? 1 : 0;
  endfunction

  task automatic t_reset();
    #1;
    chk("R1 reset addr", log_addr, 0);
    chk("R1 reset user", reserved_hit, 0);
  endtask

  task automatic t_user_wrap();
    go_user(5);
    chk("R2 step5", log_addr, 5);
    steps('h1FFF - 5);
    chk("R2 at top", log_addr, 'h1FFF);
    steps(1);
    chk("R2 wrap to 0", log_addr, 0);
  endtask

  task automatic t_cfg_space();
    pulse_jump();
    chk("R3 jump", log_addr, 'h2000);
    steps('h1FFF);
    chk("R3 cfg top", log_addr, 'h3FFF);
    steps(1);
    chk("R3 cfg wrap", log_addr, 'h2000);
    pulse_clr();
    chk("R4 clear leaves cfg", log_addr, 0);
  endtask

  task automatic t_priority();
    go_user(3);
    @(negedge clk) mode_clr = 1; cfg_jump = 1; step = 1;
    @(negedge clk) mode_clr = 0; cfg_jump = 0; step = 0;
    chk("R4 clr wins", log_addr, 0);
    @(negedge clk) cfg_jump = 1; step = 1;
    @(negedge clk) cfg_jump = 0; step = 0;
    chk("R4 jump beats step", log_addr, 'h2000);
    pulse_clr();
  endtask

  task automatic t_prot(logic [1:0] cp, int a);
    cfg_word = mk_cfg(cp);
    go_user(a);
    chk("R5 fold", phys_addr, a % 2048);
    chk("R6 R7 rd_zero", rd_zero, exp_masked(cp, a));
    chk("R7 wr_en", wr_en, 1 - exp_masked(cp, a));
  endtask

  task automatic t_mismatch();
    cfg_word = mk_cfg(2'b00);
    go_user(0);
    chk("R9 agree flag", cp_mismatch, 0);
    chk("R7 full prot", rd_zero, 1);
    for (int k = 0; k < 4; k++) begin
      int pos = (k == 3) ? 4 : 12 - 2 * k;
      @(negedge clk);
      cfg_word = mk_cfg(2'b00);
      cfg_word[pos +: 2] = 2'b01;
      #1;
      chk("R9 mismatch flag", cp_mismatch, 1);
      chk("R9 unprotected", rd_zero, 0);
      chk("R9 writable", wr_en, 1);
    end
  endtask

  task automatic t_cfg_words();
    cfg_word = mk_cfg(2'b00);
    pulse_clr(); pulse_jump();
    for (int i = 0; i < 10; i++) begin
      int ok = (i < 4 || i == 7) ? 1 : 0;
      chk("R10 wr_en", wr_en, ok);
      chk("R10 reserved", reserved_hit, 1 - ok);
      chk("R10 rd_zero", rd_zero, 0);
      steps(1);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_user_wrap();
        t_cfg_space();
        t_priority();
        t_prot(2'b11, 'h7FE);
        t_prot(2'b10, 'h3FF);
        t_prot(2'b10, 'h400);
        t_prot(2'b01, 'h1FF);
        t_prot(2'b01, 'h200);
        t_prot(2'b01, 'h800);
        t_prot(2'b00, 'h000);
        t_prot(2'b00, 'h7FE);
        t_prot(2'b00, 'h7FF); // R8 calibration word
        t_prot(2'b00, 'hFFF); // R8 folded calibration word
        t_mismatch();
        t_cfg_words();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule